// File: doc/BRIEF.md
# Chirp Arrival PPS Rebuilder

This block rebuilds a one-pulse-per-second tick from chirp arrival estimates. An upstream stage dechirps each received chirp window and transforms it. It then streams squared-magnitude values to this block: one pass per fine dechirp shift, each pass covering every coarse frequency bin. The block keeps the strongest value across the whole window and turns the winning bin and shift into a sub-sample offset. It smooths successive offsets with a moving average and adds the result to the window's start count on a local free-running counter. That sum is the averaged arrival stamp.

While a satellite-derived reference is present (calibration), the block stores the one-way time of flight: the averaged stamp minus the time of the most recent reference pulse. When the reference is absent (holdover), each new stamp minus the stored time of flight gives the next output edge. A single-cycle pulse is emitted when the local counter reaches that edge. The prediction then steps forward one period and keeps firing until a new stamp reloads it. In holdover without a stored flight time, an error flag rises and no pulse is produced.

The controller has four states. IDLE waits for `frame_start` (IDLE->SCAN, which also records the window start and clears the peak). SCAN consumes one sample per `mag_valid` and moves to STAMP after the last sample of the window (SCAN->STAMP). STAMP pushes the peak offset into the averager (STAMP->APPLY, unconditional). APPLY publishes the stamp and either learns the flight time or loads the pulse edge (APPLY->IDLE, unconditional). A `frame_start` outside IDLE is ignored.

Top module: `pps_rebuild`

## Requirements
- R1: After reset `pps_out`, `tof_valid` and `stamp_valid` are 0, and `time_now` reads 0 in the first cycle after reset is released.
- R2: Window sample k (0-based, in arrival order) belongs to shift k / NBIN and bin k % NBIN. The peak is the strictly largest magnitude; on equal magnitudes the earliest sample wins. Its offset is bin*COARSE_STEP + shift*FINE_STEP in units of 2^-FRAC_W clock ticks.
- R3: The averager holds the last 8 offsets. No `stamp_valid` pulse appears until 8 windows have completed. From then on, every window gives a one-cycle `stamp_valid` pulse, with `stamp_value` = frame_t0*2^FRAC_W + floor(sum of last 8 offsets / 8).
- R4: In calibration (`ref_present`=1), once at least one `ref_pps` has been seen, each published stamp sets `tof_value` = stamp - (time_now at the latest `ref_pps`)*2^FRAC_W and sets `tof_valid`.
- R5: Before any `ref_pps` has been seen, no flight time is stored, even when stamps are published.
- R6: In holdover (`ref_present`=0) with `tof_valid`, a published stamp schedules `pps_out` high for one cycle when `time_now` = floor((stamp - tof_value)/2^FRAC_W).
- R7: In holdover without a stored flight time, `err_no_tof` is 1 and `pps_out` stays 0.
- R8: After a scheduled pulse, further pulses follow every PERIOD ticks until a new stamp reloads the edge.
- R9: While `ref_present` is 1, `pps_out` stays 0 and the pending prediction is dropped.
- R10: `time_now` advances by exactly one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_present | input | 1 | 1 selects calibration, 0 selects holdover |
| ref_pps | input | 1 | Reference pulse, one cycle |
| frame_start | input | 1 | Starts a window (taken in IDLE) |
| frame_t0 | input | TS_W | Window start count on the local counter |
| mag_valid | input | 1 | Magnitude sample strobe |
| mag_data | input | MAG_W | Squared magnitude |
| pps_out | output | 1 | Rebuilt one-cycle pulse |
| err_no_tof | output | 1 | Holdover with no stored flight time |
| time_now | output | TS_W | Local sample counter |
| tof_value | output | TS_W+FRAC_W | Stored flight time, fractional ticks |
| tof_valid | output | 1 | Flight time stored |
| stamp_value | output | TS_W+FRAC_W | Latest averaged arrival stamp |
| stamp_valid | output | 1 | One-cycle pulse when a stamp is published |

## Verification
A wrong peak register or a wrong window index shows up as a wrong `stamp_value`. It appears two cycles after the last sample of the window, once the averager is full. A fault in the averager's running sum or ring shows as stamps that drift from the mean of the last eight offsets, or as a `stamp_valid` pulse before the eighth window. Faults in the flight-time or edge registers appear later: the pulse lands at the wrong `time_now`, is missing, or repeats at the wrong spacing. Catching them needs the bench to watch at least one full PERIOD after each holdover stamp.

// File: rtl/pps_rebuild_pkg.sv
package pps_rebuild_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_STAMP,
        ST_APPLY
    } ctl_state_t;

endpackage

// File: rtl/peak_search.sv
module peak_search #(
    parameter int MAG_W = 16,
    parameter int BIN_W = 4,
    parameter int SHF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [MAG_W-1:0] mag,
    input  logic [BIN_W-1:0] bin,
    input  logic [SHF_W-1:0] shift,
    output logic [BIN_W-1:0] best_bin,
    output logic [SHF_W-1:0] best_shift
);

    logic [MAG_W-1:0] best_mag;
    logic             have_one;
    logic             take;

    // strict compare keeps the earliest sample on ties
    assign take = en && (!have_one || (mag > best_mag));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            best_mag   <= '0;
            best_bin   <= '0;
            best_shift <= '0;
            have_one   <= 1'b0;
        end else if (take) begin
            best_mag   <= mag;
            best_bin   <= bin;
            best_shift <= shift;
            have_one   <= 1'b1;
        end
    end

endmodule

// File: rtl/avg_window.sv
module avg_window #(
    parameter int W   = 12,
    parameter int LOG = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic [W-1:0] avg,
    output logic         full
);

    localparam int DEPTH = 1 << LOG;
    localparam int SW    = W + LOG;

    logic [W-1:0]   ring [DEPTH];
    logic [LOG-1:0] wp;
    logic [LOG:0]   fill;
    logic [SW-1:0]  sum;
    logic [SW-1:0]  sum_nxt;

    assign sum_nxt = sum + SW'(din) - SW'(ring[wp]);
    assign full    = (fill == (LOG+1)'(DEPTH));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp   <= '0;
            fill <= '0;
            sum  <= '0;
            avg  <= '0;
        end else if (push) begin
            wp   <= wp + 1'b1;
            sum  <= sum_nxt;
            avg  <= W'(sum_nxt >> LOG);
            if (!full) begin
                fill <= fill + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ring[g] <= '0;
            end else if (push && (wp == LOG'(g))) begin
                ring[g] <= din;
            end
        end
    end

endmodule

// File: rtl/pps_gen.sv
module pps_gen #(
    parameter int TS_W   = 32,
    parameter int PERIOD = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TS_W-1:0] load_tick,
    input  logic            block,
    output logic [TS_W-1:0] now,
    output logic            pulse
);

    logic [TS_W-1:0] edge_t;
    logic            armed;
    logic            hit;

    assign hit   = armed && (now == edge_t);
    assign pulse = hit && !block;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now    <= '0;
            edge_t <= '0;
            armed  <= 1'b0;
        end else begin
            now <= now + 1'b1;
            if (load) begin
                edge_t <= load_tick;
                armed  <= 1'b1;
            end else if (block) begin
                armed  <= 1'b0;
            end else if (hit) begin
                edge_t <= edge_t + TS_W'(PERIOD);
            end
        end
    end

endmodule

// File: rtl/pps_rebuild.sv
module pps_rebuild
    import pps_rebuild_pkg::*;
#(
    parameter int TS_W        = 32,
    parameter int FRAC_W      = 4,
    parameter int MAG_W       = 16,
    parameter int NBIN        = 16,
    parameter int NSHIFT      = 4,
    parameter int COARSE_STEP = 64,
    parameter int FINE_STEP   = 16,
    parameter int AVG_LOG     = 3,
    parameter int PERIOD      = 1000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ref_present,
    input  logic                   ref_pps,
    input  logic                   frame_start,
    input  logic [TS_W-1:0]        frame_t0,
    input  logic                   mag_valid,
    input  logic [MAG_W-1:0]       mag_data,
    output logic                   pps_out,
    output logic                   err_no_tof,
    output logic [TS_W-1:0]        time_now,
    output logic [TS_W+FRAC_W-1:0] tof_value,
    output logic                   tof_valid,
    output logic [TS_W+FRAC_W-1:0] stamp_value,
    output logic                   stamp_valid
);

    localparam int STW   = TS_W + FRAC_W;
    localparam int TOTAL = NBIN * NSHIFT;
    localparam int IDX_W = $clog2(TOTAL);
    localparam int BIN_W = (NBIN > 1) ? $clog2(NBIN) : 1;
    localparam int SHF_W = (NSHIFT > 1) ? $clog2(NSHIFT) : 1;
    localparam int OFF_W = $clog2(NBIN * COARSE_STEP + NSHIFT * FINE_STEP + 1);

    ctl_state_t state, state_nxt;

    logic             clr_peak, scan_en, push_avg, apply_en, last_smp;
    logic [IDX_W-1:0] idx_q;
    logic [BIN_W-1:0] cur_bin, pk_bin;
    logic [SHF_W-1:0] cur_shf, pk_shf;
    logic [OFF_W-1:0] pk_off, avg_off;
    logic             avg_full;
    logic [TS_W-1:0]  t0_q, ref_stamp;
    logic             ref_seen;
    logic [STW-1:0]   stamp_calc, edge_calc;
    logic             load_edge;

    assign cur_bin  = BIN_W'(idx_q % IDX_W'(NBIN));
    assign cur_shf  = SHF_W'(idx_q / IDX_W'(NBIN));
    assign last_smp = (idx_q == IDX_W'(TOTAL - 1));
    assign pk_off   = OFF_W'(int'(pk_bin) * COARSE_STEP + int'(pk_shf) * FINE_STEP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (frame_start)             state_nxt = ST_SCAN;
            ST_SCAN:  if (mag_valid && last_smp)   state_nxt = ST_STAMP;
            ST_STAMP:                              state_nxt = ST_APPLY;
            ST_APPLY:                              state_nxt = ST_IDLE;
            default:                               state_nxt = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        clr_peak = 1'b0;
        scan_en  = 1'b0;
        push_avg = 1'b0;
        apply_en = 1'b0;
        unique case (state)
            ST_IDLE:  clr_peak = frame_start;
            ST_SCAN:  scan_en  = mag_valid;
            ST_STAMP: push_avg = 1'b1;
            ST_APPLY: apply_en = 1'b1;
            default:  ;
        endcase
    end

    peak_search #(
        .MAG_W(MAG_W), .BIN_W(BIN_W), .SHF_W(SHF_W)
    ) i_peak (
        .clk(clk), .rst_n(rst_n), .clr(clr_peak), .en(scan_en),
        .mag(mag_data), .bin(cur_bin), .shift(cur_shf),
        .best_bin(pk_bin), .best_shift(pk_shf)
    );

    avg_window #(
        .W(OFF_W), .LOG(AVG_LOG)
    ) i_avg (
        .clk(clk), .rst_n(rst_n), .push(push_avg), .din(pk_off),
        .avg(avg_off), .full(avg_full)
    );

    assign stamp_calc = {t0_q, {FRAC_W{1'b0}}} + STW'(avg_off);
    assign edge_calc  = stamp_calc - tof_value;
    assign load_edge  = apply_en && avg_full && !ref_present && tof_valid;

    pps_gen #(
        .TS_W(TS_W), .PERIOD(PERIOD)
    ) i_gen (
        .clk(clk), .rst_n(rst_n), .load(load_edge),
        .load_tick(edge_calc[STW-1:FRAC_W]), .block(ref_present),
        .now(time_now), .pulse(pps_out)
    );

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            t0_q        <= '0;
            ref_stamp   <= '0;
            ref_seen    <= 1'b0;
            tof_value   <= '0;
            tof_valid   <= 1'b0;
            stamp_value <= '0;
            stamp_valid <= 1'b0;
        end else begin
            stamp_valid <= 1'b0;
            if (ref_pps) begin
                ref_stamp <= time_now;
                ref_seen  <= 1'b1;
            end
            if (clr_peak) begin
                t0_q  <= frame_t0;
                idx_q <= '0;
            end else if (scan_en) begin
                idx_q <= idx_q + 1'b1;
            end
            if (apply_en && avg_full) begin
                stamp_value <= stamp_calc;
                stamp_valid <= 1'b1;
                if (ref_present && ref_seen) begin
                    tof_value <= stamp_calc - {ref_stamp, {FRAC_W{1'b0}}};
                    tof_valid <= 1'b1;
                end
            end
        end
    end

    assign err_no_tof = !ref_present && !tof_valid;

endmodule

// File: rtl/pps_rebuild_chk.sv
module pps_rebuild_chk #(
    parameter int TS_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ref_present,
    input logic            pps_out,
    input logic            err_no_tof,
    input logic            tof_valid,
    input logic            stamp_valid,
    input logic [TS_W-1:0] time_now
);

    // R10
    counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_now == TS_W'($past(time_now) + 1'b1));

    // R7
    no_pulse_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_no_tof |-> !pps_out);

    // R9
    no_pulse_with_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_present |-> !pps_out);

    // R4
    tof_learn_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tof_valid) |-> $past(ref_present));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pps_out |=> !pps_out);

    // R3
    stamp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid |=> !stamp_valid);

endmodule

bind pps_rebuild pps_rebuild_chk #(.TS_W(TS_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .ref_present(ref_present), .pps_out(pps_out),
    .err_no_tof(err_no_tof), .tof_valid(tof_valid), .stamp_valid(stamp_valid),
    .time_now(time_now)
);

// File: tb/test_pps_rebuild.sv
module test_pps_rebuild;

    localparam int CLK_PERIOD = 10;
    localparam int TS_W   = 32;
    localparam int FRAC_W = 4;
    localparam int STW    = TS_W + FRAC_W;
    localparam int NBIN   = 16;
    localparam int NSHIFT = 4;
    localparam int COARSE = 64;
    localparam int FINE   = 16;
    localparam int PERIOD = 1000;
    localparam int TOTAL  = NBIN * NSHIFT;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ref_present = 1'b1;
    logic            ref_pps = 1'b0;
    logic            frame_start = 1'b0;
    logic [TS_W-1:0] frame_t0 = '0;
    logic            mag_valid = 1'b0;
    logic [15:0]     mag_data = '0;
    logic            pps_out, err_no_tof, tof_valid, stamp_valid;
    logic [TS_W-1:0] time_now;
    logic [STW-1:0]  tof_value, stamp_value;

    int total = 0;
    int bad   = 0;

    // bench model state
    int             ring [8];
    int             wp = 0;
    int             fill = 0;
    logic [TS_W-1:0] last_ref = '0;
    bit             ref_seen_m = 0;
    logic [STW-1:0] tof_m = '0;
    bit             tof_ok_m = 0;
    logic [STW-1:0] got_stamp;
    bit             got_valid;
    logic [TS_W-1:0] exp_edge;

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_rebuild i_pps_rebuild (
        .clk(clk), .rst_n(rst_n), .ref_present(ref_present), .ref_pps(ref_pps),
        .frame_start(frame_start), .frame_t0(frame_t0), .mag_valid(mag_valid),
        .mag_data(mag_data), .pps_out(pps_out), .err_no_tof(err_no_tof),
        .time_now(time_now), .tof_value(tof_value), .tof_valid(tof_valid),
        .stamp_value(stamp_value), .stamp_valid(stamp_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int offset_of(input int k);
        return (k % NBIN) * COARSE + (k / NBIN) * FINE;
    endfunction

    function automatic int model_avg();
        int s = 0;
        for (int i = 0; i < 8; i++) s += ring[i];
        return s / 8;
    endfunction

    task automatic pulse_ref();
        @(negedge clk);
        ref_pps  = 1'b1;
        last_ref = time_now;
        ref_seen_m = 1;
        @(negedge clk);
        ref_pps = 1'b0;
    endtask

    // sends one window; pk2 < 0 means no tie
    task automatic send_frame(input logic [TS_W-1:0] t0, input int pk, input int pk2);
        int win;
        logic [STW-1:0] exp_stamp;
        @(negedge clk);
        frame_start = 1'b1;
        frame_t0    = t0;
        @(negedge clk);
        frame_start = 1'b0;
        for (int k = 0; k < TOTAL; k++) begin
            if ($urandom % 4 == 0) begin
                mag_valid = 1'b0;
                @(negedge clk);
            end
            mag_valid = 1'b1;
            mag_data  = (k == pk || k == pk2) ? 16'd50000 : 16'($urandom % 1000);
            @(negedge clk);
        end
        mag_valid = 1'b0;
        got_valid = 0;
        for (int i = 0; i < 4; i++) begin
            if (stamp_valid) begin
                got_valid = 1;
                got_stamp = stamp_value;
            end
            @(negedge clk);
        end
        win = (pk2 >= 0 && pk2 < pk) ? pk2 : pk;
        ring[wp] = offset_of(win);
        wp = (wp + 1) % 8;
        if (fill < 8) fill++;
        if (fill < 8) begin
            chk(!got_valid, "R3 early stamp", 64'(got_valid), 64'd0);
        end else begin
            exp_stamp = {t0, {FRAC_W{1'b0}}} + STW'(model_avg());
            chk(got_valid, "R3 stamp strobe", 64'(got_valid), 64'd1);
            chk(got_stamp == exp_stamp, "R2/R3 stamp value", 64'(got_stamp), 64'(exp_stamp));
            if (ref_present && ref_seen_m) begin
                tof_m    = exp_stamp - {last_ref, {FRAC_W{1'b0}}};
                tof_ok_m = 1;
                chk(tof_valid && tof_value == tof_m, "R4 tof", 64'(tof_value), 64'(tof_m));
            end else if (!ref_present && tof_ok_m) begin
                logic [STW-1:0] e;
                e = exp_stamp - tof_m;
                exp_edge = e[STW-1:FRAC_W];
            end
        end
    endtask

    // watch pulses up to edge + PERIOD, expecting exactly two at the right ticks
    task automatic watch_pulses();
        int seen = 0;
        while (time_now != exp_edge + TS_W'(PERIOD) + 3) begin
            if (pps_out) begin
                seen++;
                if (seen == 1)
                    chk(time_now == exp_edge, "R6 pulse time", 64'(time_now), 64'(exp_edge));
                else
                    chk(time_now == exp_edge + PERIOD, "R8 repeat time",
                        64'(time_now), 64'(exp_edge + PERIOD));
            end
            @(negedge clk);
        end
        chk(seen == 2, "R6/R8 pulse count", 64'(seen), 64'd2);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) ring[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(time_now == 0, "R1 time_now", 64'(time_now), 64'd0);
        chk(!pps_out && !tof_valid && !stamp_valid, "R1 outputs",
            64'({pps_out, tof_valid, stamp_valid}), 64'd0);
        @(negedge clk);
        chk(time_now == 1, "R10 counter step", 64'(time_now), 64'd1);

        // R7 holdover with nothing learned
        ref_present = 1'b0;
        @(negedge clk);
        chk(err_no_tof, "R7 err flag", 64'(err_no_tof), 64'd1);
        begin
            int p = 0;
            for (int i = 0; i < 50; i++) begin
                if (pps_out) p++;
                @(negedge clk);
            end
            chk(p == 0, "R7 no pulse", 64'(p), 64'd0);
        end
        ref_present = 1'b1;
        @(negedge clk);
        chk(!err_no_tof, "R7 err clears with ref", 64'(err_no_tof), 64'd0);

        // fill averager with no ref edge yet: R5
        for (int f = 0; f < 9; f++) begin
            send_frame(time_now + 40, int'($urandom % TOTAL), -1);
        end
        chk(!tof_valid, "R5 no tof without ref edge", 64'(tof_valid), 64'd0);

        // directed ties and extremes: R2
        pulse_ref();
        send_frame(time_now + 40, 5, 37);
        pulse_ref();
        send_frame(time_now + 40, 50, 3);
        pulse_ref();
        send_frame(time_now + 40, 0, -1);
        pulse_ref();
        send_frame(time_now + 40, TOTAL - 1, -1);

        // random calibration windows
        for (int f = 0; f < 8; f++) begin
            pulse_ref();
            send_frame(time_now + 40 + ($urandom % 8), int'($urandom % TOTAL), -1);
        end

        // holdover rounds
        for (int r = 0; r < 3; r++) begin
            ref_present = 1'b0;
            @(negedge clk);
            chk(!err_no_tof, "R7 no err with tof", 64'(err_no_tof), 64'd0);
            send_frame(time_now + 300 + ($urandom % 50), int'($urandom % TOTAL), -1);
            watch_pulses();
            // R9 reference back: pulses stop
            ref_present = 1'b1;
            begin
                int p = 0;
                for (int i = 0; i < PERIOD + 100; i++) begin
                    if (pps_out) p++;
                    @(negedge clk);
                end
                chk(p == 0, "R9 no pulse with ref", 64'(p), 64'd0);
            end
            pulse_ref();
            send_frame(time_now + 40 + ($urandom % 8), int'($urandom % TOTAL), -1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule